// File: doc/BRIEF.md
# I2S Bit and Frame Clock Generator

This block turns an audio master clock into the two timing clocks of an I2S link: the serial bit clock (SCLK) and the left/right frame clock (LRCLK). A single 32-bit control word, written through a simple write strobe, sets the enable, the SCLK divide ratio, the frame length in SCLK periods, the SCLK edge on which LRCLK moves, and an override flag. The override flag is passed straight out, so a neighbouring serial audio block can let these settings take priority over its own master/slave clock choice.

Both outputs run at a 50% duty cycle. LRCLK is low during the left-channel half of each frame. While the block is disabled both outputs are held low. Ratio and edge changes made while running are held back until the next frame boundary, which is the high-to-low transition of LRCLK. This way a frame in progress is never cut short.

Top module: `i2s_clk_gen`

## Requirements
- R1: After reset, sclk_o, lrclk_o and override_o are low.
- R2: override_o equals bit 29 of the most recently written control word from the first clock edge after the write, whatever the enable bit holds.
- R3: Bit 31 is the enable. A write with bit 31 clear drives sclk_o and lrclk_o low from the second clock edge after the write. While bit 31 stays clear, writes to the other fields leave both outputs low.
- R4: Bit 16 selects the SCLK ratio. Value 0 gives an SCLK period of 2 master clocks and value 1 gives 4. Each SCLK level lasts half a period.
- R5: Bits 18:17 select the frame length in SCLK periods: code 0 gives 32, code 1 gives 64, code 2 gives 128, and the reserved code 3 also gives 128. LRCLK holds each level for half a frame.
- R6: With bit 19 clear, every LRCLK transition falls on a clock edge where SCLK rises.
- R7: With bit 19 set, every LRCLK transition falls on a clock edge where SCLK falls.
- R8: Running starts at the clock edge after the enabling write, with both counters at zero and both outputs low. SCLK first toggles one half SCLK period later. LRCLK first rises on the (frame/2)-th selected SCLK edge.
- R9: Changes to bits 19:16 written while running take effect only at the next high-to-low transition of LRCLK. From that edge the counters restart under the new settings, with SCLK continuing from its current level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Audio master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word |
| sclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Left/right frame clock, low for left |
| override_o | output | 1 | Register settings override flag |

## Verification
The bench sweeps every combination of SCLK ratio, frame code (including the reserved one) and edge polarity. For each combination it compares both clocks cycle by cycle against an arithmetic model over two and a half frames. The sweep separates the divide ratios by SCLK period, the frame codes by the LRCLK toggle position, and the polarity settings by the half-period offset of each LRCLK edge. A run that changes every setting mid-frame tells an immediate update apart from one deferred to the frame boundary. Disable writes and writes made while disabled show that the outputs are forced and held low.

// File: rtl/i2s_clk_pkg.sv
package i2s_clk_pkg;

  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned EN_POS  = 31;
  localparam int unsigned OVR_POS = 29;
  localparam int unsigned POL_POS = 19;
  localparam int unsigned LR_POS  = 17;
  localparam int unsigned SC_POS  = 16;

  // divide ratios: master -> SCLK, SCLK -> LRCLK
  localparam int unsigned SC_DIV_LO = 2;
  localparam int unsigned SC_DIV_HI = 4;
  localparam int unsigned LR_DIV_0  = 32;
  localparam int unsigned LR_DIV_1  = 64;
  localparam int unsigned LR_DIV_2  = 128;

  localparam int unsigned PRE_W = (SC_DIV_HI / 2 > 1) ? $clog2(SC_DIV_HI / 2) : 1;
  localparam int unsigned LR_W  = $clog2(LR_DIV_2 / 2);

  typedef struct packed {
    logic       sc_sel;
    logic [1:0] lr_sel;
    logic       pol;
  } rate_t;

  typedef struct packed {
    logic  en;
    logic  ovr;
    rate_t rate;
  } ctrl_t;

  // master cycles per SCLK half period, minus one
  function automatic logic [PRE_W-1:0] pre_limit(input logic sc_sel);
    return sc_sel ? PRE_W'(SC_DIV_HI / 2 - 1) : PRE_W'(SC_DIV_LO / 2 - 1);
  endfunction

  // SCLK periods per LRCLK half frame, minus one; code 3 aliases the longest
  function automatic logic [LR_W-1:0] lr_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return LR_W'(LR_DIV_0 / 2 - 1);
      2'd1:    return LR_W'(LR_DIV_1 / 2 - 1);
      default: return LR_W'(LR_DIV_2 / 2 - 1);
    endcase
  endfunction

endpackage

// File: rtl/i2s_clk_ctrl.sv
module i2s_clk_ctrl
  import i2s_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              boundary_i,
  output ctrl_t             ctrl_o,
  output rate_t             act_o,
  output logic              run_o
);

  ctrl_t ctrl_q;
  rate_t act_q;
  logic  run_q;
  logic  unused_w;

  assign unused_w = ^{wr_data_i[30], wr_data_i[28:20], wr_data_i[15:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      act_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      if (wr_en_i) begin
        ctrl_q.en          <= wr_data_i[EN_POS];
        ctrl_q.ovr         <= wr_data_i[OVR_POS];
        ctrl_q.rate.pol    <= wr_data_i[POL_POS];
        ctrl_q.rate.lr_sel <= wr_data_i[LR_POS+1:LR_POS];
        ctrl_q.rate.sc_sel <= wr_data_i[SC_POS];
      end
      run_q <= ctrl_q.en;
      // idle: track register; running: reload only on a frame boundary
      if (!run_o || boundary_i) act_q <= ctrl_q.rate;
    end
  end

  assign run_o  = run_q & ctrl_q.en;
  assign ctrl_o = ctrl_q;
  assign act_o  = act_q;

  p_defer_to_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !boundary_i) |=> $stable(act_q));

endmodule

// File: rtl/i2s_sclk_gen.sv
module i2s_sclk_gen
  import i2s_clk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sc_sel_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             sclk_q;
  logic             tog;

  always_comb begin
    lim = pre_limit(sc_sel_i);
    tog = run_i && (pre_q >= lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      pre_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tog) begin
      pre_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  assign rise_o = tog & ~sclk_q;
  assign fall_o = tog &  sclk_q;
  assign sclk_o = sclk_q;

  p_pre_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (pre_q <= lim));

endmodule

// File: rtl/i2s_lrclk_gen.sv
module i2s_lrclk_gen
  import i2s_clk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       pol_i,
  input  logic [1:0] lr_sel_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       lrclk_o,
  output logic       boundary_o
);

  logic [LR_W-1:0] cnt_q;
  logic [LR_W-1:0] lim;
  logic            lr_q;
  logic            step;
  logic            wrap;

  always_comb begin
    step = pol_i ? fall_i : rise_i;
    lim  = lr_limit(lr_sel_i);
    wrap = run_i && step && (cnt_q >= lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lr_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      lr_q  <= 1'b0;
    end else if (step) begin
      if (cnt_q >= lim) begin
        cnt_q <= '0;
        lr_q  <= ~lr_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // high-to-low toggle closes a frame
  assign boundary_o = wrap & lr_q;
  assign lrclk_o    = lr_q;

  p_half_frame_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= lim));

endmodule

// File: rtl/i2s_clk_gen.sv
module i2s_clk_gen
  import i2s_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic              sclk_o,
  output logic              lrclk_o,
  output logic              override_o
);

  ctrl_t ctrl;
  rate_t act;
  logic  run;
  logic  rise;
  logic  fall;
  logic  boundary;

  i2s_clk_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .boundary_i (boundary),
    .ctrl_o     (ctrl),
    .act_o      (act),
    .run_o      (run)
  );

  i2s_sclk_gen u_sclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .sc_sel_i (act.sc_sel),
    .sclk_o   (sclk_o),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  i2s_lrclk_gen u_lrclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .pol_i      (act.pol),
    .lr_sel_i   (act.lr_sel),
    .rise_i     (rise),
    .fall_i     (fall),
    .lrclk_o    (lrclk_o),
    .boundary_o (boundary)
  );

  assign override_o = ctrl.ovr;

  p_override_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (override_o == $past(wr_data_i[OVR_POS])));

  p_idle_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |=> (!sclk_o && !lrclk_o));

  p_lr_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !act.pol) |=> ($stable(lrclk_o) || $rose(sclk_o)));

  p_lr_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && act.pol) |=> ($stable(lrclk_o) || $fell(sclk_o)));

endmodule

// File: tb/tb_i2s_clk_gen.sv
module tb_i2s_clk_gen;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        sclk_o, lrclk_o, override_o;

  int n_chk = 0;
  int n_err = 0;

  i2s_clk_gen dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .sclk_o     (sclk_o),
    .lrclk_o    (lrclk_o),
    .override_o (override_o)
  );

  always #5 clk_i = ~clk_i;

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input int en, input int ovr, input int pol,
                                      input int lr, input int sc);
    logic [31:0] w;
    w = '0;
    w[31] = en[0];
    w[29] = ovr[0];
    w[19] = pol[0];
    w[18:17] = lr[1:0];
    w[16] = sc[0];
    return w;
  endfunction

  // t edges after start, h master cycles per SCLK half, half = SCLK periods per LRCLK level
  function automatic int m_sclk(input int t, input int h, input int s0);
    return s0 ^ ((t / h) & 1);
  endfunction

  function automatic int m_lr(input int t, input int h, input int half, input int pol, input int s0);
    int k, c;
    k = t / h;
    if (pol != 0) c = (s0 != 0) ? (k + 1) / 2 : k / 2;
    else          c = (s0 != 0) ? k / 2 : (k + 1) / 2;
    return (c / half) & 1;
  endfunction

  function automatic int half_of(input int lr);
    return (lr == 0) ? 16 : (lr == 1) ? 32 : 64;
  endfunction

  // returns at the falling edge after the write edge, strobe released
  task automatic wr(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "sclk in reset", int'(sclk_o), 0);
    chk("R1", "lrclk in reset", int'(lrclk_o), 0);
    chk("R1", "override in reset", int'(override_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "sclk after reset", int'(sclk_o), 0);
    chk("R1", "override after reset", int'(override_o), 0);

    // R3: disabled writes keep outputs low; R2 override without enable
    wr(mkw(0, 1, 1, 2, 1));
    chk("R2", "override while disabled", int'(override_o), 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      chk("R3", "sclk disabled", int'(sclk_o), 0);
      chk("R3", "lrclk disabled", int'(lrclk_o), 0);
    end

    // sweep every ratio and polarity combination
    for (int sc = 0; sc < 2; sc++) begin
      for (int lr = 0; lr < 4; lr++) begin
        for (int pol = 0; pol < 2; pol++) begin
          int h, half, n;
          string lreq;
          h = sc + 1;
          half = half_of(lr);
          n = (4 * half * h * 5) / 2 + 3;
          lreq = (lr == 3) ? "R5" : (pol != 0) ? "R7" : "R6";
          wr(mkw(1, sc ^ pol, pol, lr, sc));
          chk("R2", "override after write", int'(override_o), sc ^ pol);
          for (int t = 0; t <= n; t++) begin
            @(negedge clk_i);
            chk((t == 0) ? "R8" : "R4", "sclk", int'(sclk_o), m_sclk(t, h, 0));
            chk((t == 0) ? "R8" : lreq, "lrclk", int'(lrclk_o), m_lr(t, h, half, pol, 0));
          end
          wr(mkw(0, 0, pol, lr, sc));
          for (int i = 0; i < 4; i++) begin
            @(negedge clk_i);
            chk("R3", "sclk after disable", int'(sclk_o), 0);
            chk("R3", "lrclk after disable", int'(lrclk_o), 0);
          end
        end
      end
    end

    // R9: settings written mid-frame wait for the frame boundary (t = 63)
    wr(mkw(1, 0, 0, 0, 0));
    for (int t = 0; t <= 300; t++) begin
      @(negedge clk_i);
      if (t == 21) begin
        wr_en_i = 1'b0;
        chk("R2", "override after mid-run write", int'(override_o), 1);
      end
      if (t <= 63) begin
        chk("R9", "sclk before boundary", int'(sclk_o), m_sclk(t, 1, 0));
        chk("R9", "lrclk before boundary", int'(lrclk_o), m_lr(t, 1, 16, 0, 0));
      end else begin
        chk("R9", "sclk after boundary", int'(sclk_o), m_sclk(t - 63, 2, 1));
        chk("R9", "lrclk after boundary", int'(lrclk_o), m_lr(t - 63, 2, 32, 1, 1));
      end
      if (t == 20) begin
        wr_en_i = 1'b1;
        wr_data_i = mkw(1, 1, 1, 1, 1);
      end
    end
    wr(32'h0);
    @(negedge clk_i);
    chk("R3", "sclk final disable", int'(sclk_o), 0);
    chk("R3", "lrclk final disable", int'(lrclk_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule